// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter. It advances on prescaled ticks of an instruction-rate clock enable and compares its value with an 8-bit period register. When the count equals the period, the next counting step returns the count to zero instead of incrementing it. At the same moment the block raises a one-cycle, unscaled match pulse, which a PWM stage can use as a time base or a serial port can use as a shift clock.

The match events also feed a 4-bit postscaler. When the postscaler completes its programmed number of matches, it sets a sticky flag. An enable bit gates that flag onto the interrupt request. Software reaches the count, the period, the control word and the flag/enable pair through a small write port and a combinational read port.

Top module: `period_timer`

## Requirements
- R1: After reset the count reads 0x00, the period reads 0xFF, the control word reads 0x00, and the flag, enable and `irq` are all 0.
- R2: The prescale field (control bits 1:0) sets how many `tick_en` pulses make one counting step: 00 gives 1, 01 gives 4, and 10 or 11 give 16.
- R3: The counting step taken while the count equals the period loads zero. The match output is high for exactly the one clock cycle that follows that step, which is the cycle in which the count first reads zero.
- R4: With postscale field n (control bits 6:3), the flag sets together with every (n+1)th match, counted from the last clear of the postscaler.
- R5: The flag (status bit 0, address 3) stays set until a write to address 3 with data bit 0 = 1. When a set and that clear land on the same edge, the flag ends up set.
- R6: `irq` is high exactly when the flag and the enable bit (status bit 1, written through address 3 bit 1) are both 1.
- R7: While the timer-on bit (control bit 2) is 0, or while `tick_en` is low, the count, the prescaler and the postscaler do not move.
- R8: A write to the count register (address 0) loads the written value and clears both the prescaler and the postscaler progress.
- R9: The control register (address 2) stores bits 6:0 of the written data, and its bit 7 always reads 0. The period register is at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Instruction-rate tick enable (clock / 4) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 count, 1 period, 2 control, 3 status |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Combinational read data |
| match_o | output | 1 | Unscaled one-cycle match pulse |
| irq | output | 1 | Flag gated by the enable bit |

## Verification
The hardest case to reach from the ports is a flag-setting match that lands on the same clock edge as a software clear of the flag. The bench reaches it by programming a zero period, 1:1 prescaling and 1:1 postscaling, so that every tick is a flag-setting match. It then drives the tick and the clearing write in the same cycle. A second awkward case is prescaler or postscaler progress that is only partly used up. The bench leaves that progress at a known value, then shows through the count and the flag that a count write or a timer-off interval left it as the requirements say.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_STAT   = 2'd3;

  typedef struct packed {
    logic [3:0] post_sel;
    logic       run;
    logic [1:0] pre_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Last prescaler count value before a step is released.
  function automatic logic [3:0] pre_last(input logic [1:0] sel);
    case (sel)
      2'b00:   pre_last = 4'd0;
      2'b01:   pre_last = 4'd3;
      default: pre_last = 4'd15;
    endcase
  endfunction

  // True when a counter at value cnt has reached the last slot of a 1:(last+1) divider.
  function automatic logic div_done(input logic [3:0] cnt, input logic [3:0] last);
    div_done = (cnt >= last);
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic         clr,
  input  logic [W-1:0] last,
  output logic         step,
  output logic [W-1:0] cnt
);
  import tmr_pkg::*;

  logic at_end;

  assign at_end = div_done(cnt, last);
  assign step   = advance & ~clr & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (advance) cnt <= at_end ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         wrap,
  output logic         match_q
);

  assign wrap = step & ~load & (count == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= wrap ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= wrap;
  end

endmodule

// File: rtl/tmr_postscaler.sv
module tmr_postscaler #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pulse,
  input  logic         clr,
  input  logic [W-1:0] sel,
  output logic         hit,
  output logic [W-1:0] cnt
);
  import tmr_pkg::*;

  logic at_end;

  assign at_end = div_done(cnt, sel);
  assign hit    = pulse & ~clr & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (pulse) cnt <= at_end ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/period_timer.sv
module period_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 4,
  parameter int PST_W = 4,
  parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic             match_o,
  output logic             irq
);
  import tmr_pkg::*;

  localparam int PAD_CNT = 8 - CNT_W;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] count_q;
  logic             flag_q;
  logic             ie_q;

  // Named internal events, brought out for the checker.
  logic             cnt_load;
  logic             flag_clr;
  logic             tick_run;
  logic             cnt_step;
  logic             cnt_wrap;
  logic             post_hit;
  logic [PRE_W-1:0] pre_cnt;
  logic [PST_W-1:0] post_cnt;

  assign cnt_load = wr_en & (wr_addr == ADDR_COUNT);
  assign flag_clr = wr_en & (wr_addr == ADDR_STAT) & wr_data[0];
  assign tick_run = tick_en & ctrl_q.run;

  // Register file.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= PERIOD_RST;
      ie_q     <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_PERIOD: period_q <= wr_data[CNT_W-1:0];
        ADDR_CTRL:   ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_STAT:   ie_q     <= wr_data[1];
        default:     ;
      endcase
    end
  end

  // The flag is sticky; a set on the same edge as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (post_hit) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  tmr_prescaler #(.W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (tick_run),
    .clr     (cnt_load),
    .last    (PRE_W'(pre_last(ctrl_q.pre_sel))),
    .step    (cnt_step),
    .cnt     (pre_cnt)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (cnt_step),
    .load     (cnt_load),
    .load_val (wr_data[CNT_W-1:0]),
    .period   (period_q),
    .count    (count_q),
    .wrap     (cnt_wrap),
    .match_q  (match_o)
  );

  tmr_postscaler #(.W(PST_W)) u_post (
    .clk   (clk),
    .rst_n (rst_n),
    .pulse (cnt_wrap),
    .clr   (cnt_load),
    .sel   (PST_W'(ctrl_q.post_sel)),
    .hit   (post_hit),
    .cnt   (post_cnt)
  );

  assign irq = flag_q & ie_q;

  always_comb begin
    case (rd_addr)
      ADDR_COUNT:  rd_data = {{PAD_CNT{1'b0}}, count_q};
      ADDR_PERIOD: rd_data = {{PAD_CNT{1'b0}}, period_q};
      ADDR_CTRL:   rd_data = {1'b0, ctrl_q};
      default:     rd_data = {6'b0, ie_q, flag_q};
    endcase
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 4,
  parameter int PST_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             run,
  input logic             cnt_load,
  input logic             cnt_step,
  input logic             flag_clr,
  input logic             post_hit,
  input logic             flag_q,
  input logic [CNT_W-1:0] count_q,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [PST_W-1:0] post_cnt,
  input logic [1:0]       rd_addr,
  input logic [7:0]       rd_data,
  input logic             match_o
);

  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_step |-> (tick_en && run)); // R7

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick_en && run) && !cnt_load) |=> $stable(count_q)); // R7

  AST_MATCH_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> (count_q == '0)); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    post_hit |=> flag_q); // R4

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> (pre_cnt == '0 && post_cnt == '0)); // R8

  AST_CTRL_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd2) |-> !rd_data[7]); // R9

endmodule

bind period_timer tmr_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PST_W(PST_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .run      (ctrl_q.run),
  .cnt_load (cnt_load),
  .cnt_step (cnt_step),
  .flag_clr (flag_clr),
  .post_hit (post_hit),
  .flag_q   (flag_q),
  .count_q  (count_q),
  .pre_cnt  (pre_cnt),
  .post_cnt (post_cnt),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .match_o  (match_o)
);

// File: tb/test_period_timer.sv
module test_period_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       match_o;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  int mcnt  = 0;
  bit done  = 0;

  period_timer i_period_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .match_o(match_o), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (match_o) mcnt++;

  typedef struct packed {
    logic [1:0]  pre;
    logic [3:0]  post;
    logic [7:0]  per;
    logic [15:0] nt;
    logic [7:0]  ecnt;
    logic        eflag;
    logic [7:0]  ematch;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd0,  8'd5,   16'd14,  8'd2,  1'b1, 8'd2},
    '{2'd1, 4'd0,  8'd3,   16'd30,  8'd3,  1'b1, 8'd1},
    '{2'd2, 4'd0,  8'd1,   16'd70,  8'd0,  1'b1, 8'd2},
    '{2'd3, 4'd0,  8'd0,   16'd33,  8'd0,  1'b1, 8'd2},
    '{2'd0, 4'd2,  8'd2,   16'd8,   8'd2,  1'b0, 8'd2},
    '{2'd0, 4'd2,  8'd2,   16'd9,   8'd0,  1'b1, 8'd3},
    '{2'd0, 4'd15, 8'd0,   16'd15,  8'd0,  1'b0, 8'd15},
    '{2'd0, 4'd15, 8'd0,   16'd16,  8'd0,  1'b1, 8'd16},
    '{2'd0, 4'd3,  8'd255, 16'd300, 8'd44, 1'b0, 8'd1},
    '{2'd1, 4'd1,  8'd4,   16'd42,  8'd0,  1'b1, 8'd2}
  };

  function automatic logic [7:0] ctl(input int post, input int on, input int pre);
    ctl = 8'((post << 3) | (on << 2) | pre);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  // One tick_en pulse every gap+2 cycles.
  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic setup(input int pre, input int post, input int per, input int cval);
    wr(2'd2, ctl(post, 0, pre));
    wr(2'd1, 8'(per));
    wr(2'd0, 8'(cval));
    wr(2'd3, 8'h01);
    mcnt = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1: reset values
    rd(2'd0, v); check("R1 count", v, 8'h00);
    rd(2'd1, v); check("R1 period", v, 8'hFF);
    rd(2'd2, v); check("R1 control", v, 8'h00);
    rd(2'd3, v); check("R1 status", v, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 match", match_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, v); check("R1 period after release", v, 8'hFF);

    // Vector table: R2 prescale, R3 wrap and match, R4 postscale
    for (int k = 0; k < NV; k++) begin
      setup(VECS[k].pre, VECS[k].post, VECS[k].per, 0);
      wr(2'd2, ctl(VECS[k].post, 1, VECS[k].pre));
      ticks(VECS[k].nt, 2);
      repeat (3) @(negedge clk);
      wr(2'd2, ctl(VECS[k].post, 0, VECS[k].pre));
      rd(2'd0, v); check($sformatf("R2 R3 count vec%0d", k), v, VECS[k].ecnt);
      check($sformatf("R3 matches vec%0d", k), mcnt, VECS[k].ematch);
      rd(2'd3, v); check($sformatf("R4 flag vec%0d", k), v[0], VECS[k].eflag);
    end

    // R3: match high exactly one cycle, in the cycle where count reads 0
    setup(0, 0, 2, 2);
    wr(2'd2, ctl(0, 1, 0));
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    rd_addr = 2'd0; #1;
    check("R3 match pulse", match_o, 1);
    check("R3 count zero", rd_data, 0);
    @(negedge clk);
    check("R3 match one cycle", match_o, 0);

    // R5: sticky flag and set-wins
    setup(0, 0, 0, 0);
    wr(2'd2, ctl(0, 1, 0));
    ticks(1, 0);
    repeat (4) @(negedge clk);
    rd(2'd3, v); check("R5 flag sticky", v[0], 1);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rd(2'd3, v); check("R5 set wins over clear", v[0], 1);
    wr(2'd3, 8'h01);
    rd(2'd3, v); check("R5 clear", v[0], 0);

    // R6: irq gating
    wr(2'd3, 8'h02);
    #1 check("R6 irq flag0 en1", irq, 0);
    ticks(1, 0);
    #1 check("R6 irq flag1 en1", irq, 1);
    wr(2'd3, 8'h00);
    #1 check("R6 irq flag1 en0", irq, 0);
    rd(2'd3, v); check("R6 flag kept", v[0], 1);

    // R7: timer off holds count and prescaler
    setup(1, 0, 200, 10);
    wr(2'd2, ctl(0, 1, 1));
    ticks(2, 2);
    wr(2'd2, ctl(0, 0, 1));
    ticks(5, 2);
    rd(2'd0, v); check("R7 hold while off", v, 10);
    wr(2'd2, ctl(0, 1, 1));
    ticks(2, 2);
    rd(2'd0, v); check("R7 prescaler held", v, 11);
    repeat (10) @(negedge clk);
    rd(2'd0, v); check("R7 no tick no step", v, 11);

    // R8: count write clears prescaler
    setup(1, 0, 200, 20);
    wr(2'd2, ctl(0, 1, 1));
    ticks(3, 2);
    wr(2'd0, 8'd20);
    ticks(3, 2);
    rd(2'd0, v); check("R8 prescaler cleared", v, 20);
    ticks(1, 2);
    rd(2'd0, v); check("R8 step after 4", v, 21);

    // R8: count write clears postscaler
    setup(0, 1, 0, 0);
    wr(2'd2, ctl(1, 1, 0));
    ticks(1, 2);
    rd(2'd3, v); check("R8 one match flag", v[0], 0);
    wr(2'd0, 8'd0);
    ticks(1, 2);
    rd(2'd3, v); check("R8 postscaler cleared", v[0], 0);
    ticks(1, 2);
    rd(2'd3, v); check("R8 second match sets", v[0], 1);

    // R9: control layout
    wr(2'd2, 8'hFF);
    rd(2'd2, v); check("R9 msb reads 0", v, 8'h7F);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h5A);
    rd(2'd1, v); check("R9 period address", v, 8'h5A);

    finish_run();
  end

endmodule